// File: doc/BRIEF.md
# Byte-Serial CRC-32 Generator

This block computes a 32-bit cyclic redundancy check over a byte stream, folding one byte into a running remainder on every clock where a byte is presented. It uses the generator polynomial x^32 + x^29 + x^18 + x^14 + x^3 + 1. That polynomial is written 0x20044009 with the x^32 term implied. Bits are processed most significant first. No bit of the input or the output is reversed, and no final XOR is applied, so the output is the raw remainder.

A computation begins with an init pulse. The pulse loads a seed from an input port. The usual seed is 0xFFFFFFFF, but any earlier partial remainder may be loaded to resume a message that was split into pieces. The caller marks the final byte, and the block raises a one-cycle done flag when the finished remainder is on the output. A build parameter chooses one of two fold datapaths: a 256-row lookup table computed at elaboration, or a bit-serial XOR network. Both give identical results.

Top module: `crc32_byte_engine`

## Requirements
- R1: After reset, `remainder` is 0xFFFFFFFF and `done` is 0.
- R2: A clock edge with `initPulse` high makes `remainder` equal `seed` from the next cycle on.
- R3: Each clock edge with `byteValid` high and `initPulse` low folds `dataByte` into the remainder MSB-first with polynomial 0x20044009. The result is `{rem[23:0],8'h00} ^ T[rem[31:24] ^ dataByte]`. Row T[i] is formed by placing i in bits 31:24 and then making eight left shifts, XORing in 0x20044009 after each shift whose bit 31 was set beforehand.
- R4: Seed 0xFFFFFFFF followed by the bytes 0x01, 0x02, 0x03, 0x04 gives 0xF33CB7D3.
- R5: On edges with both `byteValid` and `initPulse` low, `remainder` holds its value, whatever `dataByte` and `lastByte` carry.
- R6: When `initPulse` and `byteValid` are high on the same edge, the seed is loaded and the byte is discarded.
- R7: Splitting a message, then loading the partial remainder as the seed for the second part, gives the same result as processing the whole message in one pass.
- R8: `done` is high for exactly the cycle after an edge where `lastByte` is high together with `byteValid` or `initPulse`, and `remainder` holds the final value in that cycle. Otherwise `done` is low.
- R9: A zero-length message (init with `lastByte` high and no data bytes) gives `done` with `remainder` equal to the seed.
- R10: The table variant (USE_TABLE=1) and the XOR variant (USE_TABLE=0) give identical remainders for any input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| initPulse | input | 1 | Load `seed` into the remainder |
| seed | input | 32 | Start or resume remainder |
| byteValid | input | 1 | `dataByte` is folded this cycle |
| dataByte | input | 8 | Message byte |
| lastByte | input | 1 | Marks the final byte, or an empty message when given with init |
| remainder | output | 32 | Running CRC remainder |
| done | output | 1 | Final remainder is valid this cycle |

## Verification
The hardest case to reach is an edge where init, a valid byte and the last-byte mark all arrive together. The seed must win, and `done` must still fire with the seed as the result. A directed task drives exactly that edge. A second task drives init together with a valid byte in the middle of a stream. Random messages of 0 to 64 bytes, with random seeds, are run through both variants at once and compared against a bit-serial model in the bench. Each message also reaches the zero-length and single-byte edges of `done`.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int CRC_W = 32;
  localparam int BYTE_W = 8;
  localparam int ROWS = 1 << BYTE_W;
  localparam logic [CRC_W-1:0] POLY = 32'h2004_4009;

  typedef struct packed {
    logic load;
    logic fold;
  } crcStrobes_t;

  // Bit-serial MSB-first fold of one byte into a remainder.
  function automatic logic [CRC_W-1:0] serialFold(input logic [CRC_W-1:0] rem,
                                                  input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = rem ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int k = 0; k < BYTE_W; k++) begin
      if (r[CRC_W-1]) r = (r << 1) ^ POLY;
      else            r = r << 1;
    end
    return r;
  endfunction

  // One lookup row: index in the top byte, then eight shift steps.
  function automatic logic [CRC_W-1:0] tableRow(input int idx);
    logic [CRC_W-1:0] r;
    r = CRC_W'(idx) << (CRC_W - BYTE_W);
    for (int k = 0; k < BYTE_W; k++) begin
      if (r[CRC_W-1]) r = (r << 1) ^ POLY;
      else            r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/crc32_ctrl.sv
module crc32_ctrl
  import crc32_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initPulse,
  input  logic        byteValid,
  input  logic        lastByte,
  output crcStrobes_t strobes,
  output logic        done
);
  logic finishing;

  always_comb begin
    strobes.load = initPulse;
    strobes.fold = byteValid && !initPulse;
    finishing    = lastByte && (byteValid || initPulse);
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= finishing;
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (lastByte && (byteValid || initPulse)) |=> done);  // R8
  AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (!lastByte) |=> !done);  // R8
endmodule

// File: rtl/crc32_datapath.sv
module crc32_datapath
  import crc32_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1,
  parameter logic [CRC_W-1:0] RESET_REM = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strobes,
  input  logic [CRC_W-1:0]  seedIn,
  input  logic [BYTE_W-1:0] dataByte,
  output logic [CRC_W-1:0]  remQ
);
  logic [CRC_W-1:0] foldNext;

  generate
    if (USE_TABLE) begin : gTable
      logic [CRC_W-1:0] rows [ROWS];
      logic [BYTE_W-1:0] rowSel;
      for (genvar i = 0; i < ROWS; i++) begin : gRow
        localparam logic [CRC_W-1:0] ROW_VAL = tableRow(i);
        assign rows[i] = ROW_VAL;
      end
      always_comb begin
        rowSel   = remQ[CRC_W-1 -: BYTE_W] ^ dataByte;
        foldNext = {remQ[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ rows[rowSel];
      end
      always_ff @(posedge clk) begin
        if (rstN && strobes.fold)
          AST_TABLE_EQ_SERIAL: assert (foldNext == serialFold(remQ, dataByte));  // R10
      end
    end else begin : gXor
      always_comb foldNext = serialFold(remQ, dataByte);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             remQ <= RESET_REM;
    else if (strobes.load) remQ <= seedIn;
    else if (strobes.fold) remQ <= foldNext;
  end

  AST_SEED_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (remQ == $past(seedIn)));  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.fold) |=> $stable(remQ));  // R5
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
  import crc32_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initPulse,
  input  logic [31:0] seed,
  input  logic        byteValid,
  input  logic [7:0]  dataByte,
  input  logic        lastByte,
  output logic [31:0] remainder,
  output logic        done
);
  crcStrobes_t strobes;

  crc32_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .byteValid(byteValid),
    .lastByte(lastByte), .strobes(strobes), .done(done)
  );

  crc32_datapath #(.USE_TABLE(USE_TABLE)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .seedIn(seed),
    .dataByte(dataByte), .remQ(remainder)
  );

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (initPulse && byteValid) |=> (remainder == $past(seed)));  // R6
endmodule

// File: tb/crc32_byte_engine_tb_top.sv
module crc32_byte_engine_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initPulse = 1'b0;
  logic [31:0] seed = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        lastByte = 1'b0;
  logic [31:0] remainder, remainderX;
  logic        done, doneX;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [7:0] msg [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc32_byte_engine #(.USE_TABLE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .seed(seed),
    .byteValid(byteValid), .dataByte(dataByte), .lastByte(lastByte),
    .remainder(remainder), .done(done)
  );

  crc32_byte_engine #(.USE_TABLE(1'b0)) dutXor_i (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .seed(seed),
    .byteValid(byteValid), .dataByte(dataByte), .lastByte(lastByte),
    .remainder(remainderX), .done(doneX)
  );

  function automatic logic [31:0] refFold(input logic [31:0] rem, input logic [7:0] b);
    logic [31:0] r = rem;
    for (int bitIdx = 7; bitIdx >= 0; bitIdx--) begin
      logic fb = r[31] ^ b[bitIdx];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h2004_4009;
    end
    return r;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    initPulse = 1'b0; byteValid = 1'b0; lastByte = 1'b0;
  endtask

  // Init, then len bytes from msg; returns at the negedge where the result shows.
  task automatic runMsg(input logic [31:0] s, input int len);
    @(negedge clk);
    initPulse = 1'b1; seed = s; byteValid = 1'b0; lastByte = (len == 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      initPulse = 1'b0; byteValid = 1'b1; dataByte = msg[i]; lastByte = (i == len - 1);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic testReset();
    check32("R1 reset remainder", remainder, 32'hFFFF_FFFF);
    check32("R1 reset done", {31'b0, done}, 32'd0);
  endtask

  task automatic testVector();
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h03; msg[3] = 8'h04;
    runMsg(32'hFFFF_FFFF, 4);
    check32("R4 known vector", remainder, 32'hF33C_B7D3);
    check32("R8 done after last", {31'b0, done}, 32'd1);
    check32("R10 xor variant vector", remainderX, 32'hF33C_B7D3);
  endtask

  task automatic testSingleFold();
    logic [31:0] s = 32'h1234_5678;
    msg[0] = 8'hA5;
    runMsg(s, 1);
    check32("R3 single fold", remainder, refFold(s, 8'hA5));
    check32("R2 seed then fold path", remainderX, refFold(s, 8'hA5));
  endtask

  task automatic testIdleHold();
    logic [31:0] held = remainder;
    for (int i = 0; i < 5; i++) begin
      dataByte = 8'(i * 37 + 11); lastByte = i[0];
      @(negedge clk);
      check32("R5 hold when idle", remainder, held);
      check32("R8 done low when idle", {31'b0, done}, 32'd0);
    end
    idle();
  endtask

  task automatic testInitPriority();
    msg[0] = 8'h55; msg[1] = 8'h66;
    runMsg(32'hFFFF_FFFF, 2);
    @(negedge clk);
    initPulse = 1'b1; seed = 32'hCAFE_F00D; byteValid = 1'b1; dataByte = 8'hAA; lastByte = 1'b0;
    @(negedge clk);
    idle();
    check32("R6 init beats data", remainder, 32'hCAFE_F00D);
    check32("R2 seed loaded", remainderX, 32'hCAFE_F00D);
    initPulse = 1'b1; seed = 32'h0BAD_BEEF; byteValid = 1'b1; lastByte = 1'b1;
    @(negedge clk);
    idle();
    check32("R6 init beats last data", remainder, 32'h0BAD_BEEF);
    check32("R8 done with init and last", {31'b0, done}, 32'd1);
  endtask

  task automatic testZeroLength();
    runMsg(32'h89AB_CDEF, 0);
    check32("R9 empty message remainder", remainder, 32'h89AB_CDEF);
    check32("R9 empty message done", {31'b0, done}, 32'd1);
    @(negedge clk);
    check32("R8 done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic testContinue();
    logic [31:0] whole, part;
    logic [7:0] saved [10];
    for (int i = 0; i < 10; i++) saved[i] = 8'(i * 29 + 3);
    for (int i = 0; i < 10; i++) msg[i] = saved[i];
    runMsg(32'hFFFF_FFFF, 10);
    whole = remainder;
    for (int i = 0; i < 4; i++) msg[i] = saved[i];
    runMsg(32'hFFFF_FFFF, 4);
    part = remainder;
    for (int i = 0; i < 6; i++) msg[i] = saved[i + 4];
    runMsg(part, 6);
    check32("R7 resumed equals whole", remainder, whole);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 40; n++) begin
      int len = (n == 0) ? 0 : ((n == 1) ? 64 : int'($urandom_range(0, 64)));
      logic [31:0] s = (n[0]) ? 32'hFFFF_FFFF : $urandom;
      logic [31:0] exp = s;
      for (int i = 0; i < len; i++) begin
        msg[i] = 8'($urandom);
        exp = refFold(exp, msg[i]);
      end
      runMsg(s, len);
      check32("R3 random message", remainder, exp);
      check32("R10 xor variant random", remainderX, exp);
      check32("R8 done random", {31'b0, doneX}, 32'd1);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testVector();
    testSingleFold();
    testIdleHold();
    testInitPriority();
    testZeroLength();
    testContinue();
    testRandom();
    finishRun();
  end
endmodule